// File: doc/BRIEF.md
# SPI Master on a Single System Clock

This block is a serial peripheral interface master that runs entirely on one fast system clock. It does not create a second clock. It counts system cycles to build the serial clock, and it moves all of its slower serial timing with single-cycle enable conditions. The host writes a word with a one-cycle strobe. The block then drives the serial clock, the data-out line and an active-low slave select, and it samples the data-in line. The received word comes back with a one-cycle valid pulse.

Clock polarity and clock phase are set by two mode inputs, which are captured when a transfer starts. Before the current word ends, a request pulse invites the host to supply the next word. A word written in time is sent straight after the current one, with slave select held low and the serial clock keeping an even rhythm. If no word arrives, slave select is released and the serial clock rests at its idle level. The serial clock, the data-out line and slave select all come from one output register stage. This keeps them phase-aligned as they leave the block.

Top module: `spi_clken_master`

## Requirements
- R1: During a transfer, each serial clock level lasts exactly CLK_DIV/2 system cycles, so one serial bit takes CLK_DIV cycles.
- R2: While slave select is high, the serial clock sits at the level of `mode_cpol` from the previous cycle.
- R3: A write strobe while idle pulls `ss_n` low on the second rising edge after the strobe. For a single word, `ss_n` stays low for exactly WORD_W*CLK_DIV cycles.
- R4: Data goes out most significant bit first. A receiver that samples on the first edge of each bit when `mode_cpha`=0, or on the second edge when `mode_cpha`=1, recovers the written word in all four modes.
- R5: While slave select stays low, `mosi` changes only in a cycle in which `sck` also changes.
- R6: `miso` is shifted in most significant bit first at the sampling edge. `rx_data` holds the word during a one-cycle `rx_valid` pulse, which occurs only while `ss_n` is low.
- R7: `data_req` is a one-cycle pulse issued PREFETCH cycles before the last cycle of each word. For a final word, `ss_n` rises PREFETCH+2 cycles after the `data_req` cycle.
- R8: A word written after a request and no later than the last cycle of the current word follows with no gap. Slave select stays low for the whole run of words.
- R9: When no further word is written, `ss_n` returns high right after the final bit.
- R10: The reset is synchronous. It forces `ss_n` high, `rx_valid` low and `sck` to its idle level, and it also aborts a transfer in progress.
- R11: Elaboration fails unless CLK_DIV is even and at least 2, and PREFETCH is between 1 and WORD_W*CLK_DIV-1.
- R12: Changing the mode inputs during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_cpol | input | 1 | Idle level of the serial clock |
| mode_cpha | input | 1 | 0: sample on the first edge of a bit; 1: sample on the second edge |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | WORD_W | Word to transmit |
| data_req | output | 1 | Request for the next word |
| rx_data | output | WORD_W | Received word |
| rx_valid | output | 1 | One-cycle strobe marking rx_data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Slave select, active low |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with WORD_W=8, CLK_DIV=4 and PREFETCH=3. These values give two system cycles per serial clock level. That leaves room to measure half-periods exactly and to reply to a request within the prefetch window. With 32 cycles per word, a three-word run and the request-to-release distance can be checked cycle by cycle. Runs cover each polarity and phase, mode pins toggled during a word, and a reset that lands mid-word.

// File: rtl/spi_clken_master.sv
module spi_clken_master #(
  parameter int WORD_W   = 8,
  parameter int CLK_DIV  = 4,
  parameter int PREFETCH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_cpol,
  input  logic              mode_cpha,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              data_req,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  input  logic              miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int WCYC = WORD_W * CLK_DIV;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = $clog2(WORD_W);
  localparam int PW   = $clog2(WCYC);

  // R11: parameter legality
  if (CLK_DIV < 2 || (CLK_DIV % 2) != 0 || PREFETCH < 1 || PREFETCH > WCYC - 1) begin : g_bad_param
    $error("spi_clken_master: illegal CLK_DIV or PREFETCH");
  end

  logic              busy, half_q, cpol_q, cpha_q, nxt_vld;
  logic [DW-1:0]     div_q;
  logic [BW-1:0]     bit_q;
  logic [PW-1:0]     pos_q;
  logic [WORD_W-1:0] tx_sh, rx_sh, nxt_q;

  wire tick     = busy && div_q == DW'(HALF - 1);
  wire bit_end  = tick && half_q;
  wire last_bit = bit_q == BW'(WORD_W - 1);
  wire word_end = bit_end && last_bit;
  wire more     = nxt_vld || wr_en;
  wire samp     = busy && half_q && div_q == '0;

  assign data_req = busy && pos_q == PW'(WCYC - 1 - PREFETCH);
  assign rx_data  = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      half_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      pos_q    <= '0;
      nxt_vld  <= 1'b0;
      nxt_q    <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      sck      <= mode_cpol;
      mosi     <= 1'b0;
      ss_n     <= 1'b1;
    end else begin
      sck      <= busy ? (cpol_q ^ cpha_q ^ half_q) : mode_cpol;
      mosi     <= tx_sh[WORD_W-1];
      ss_n     <= ~busy;
      rx_valid <= samp && last_bit;
      if (samp) rx_sh <= {rx_sh[WORD_W-2:0], miso};
      if (!busy) begin
        nxt_vld <= 1'b0;
        if (wr_en) begin
          busy   <= 1'b1;
          tx_sh  <= wr_data;
          cpol_q <= mode_cpol;
          cpha_q <= mode_cpha;
          half_q <= 1'b0;
          div_q  <= '0;
          bit_q  <= '0;
          pos_q  <= '0;
        end
      end else begin
        pos_q <= word_end ? '0 : pos_q + 1'b1;
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) half_q <= ~half_q;
        if (bit_end) begin
          bit_q <= last_bit ? '0 : bit_q + 1'b1;
          tx_sh <= last_bit ? (wr_en ? wr_data : nxt_q) : {tx_sh[WORD_W-2:0], 1'b0};
        end
        if (word_end) begin
          nxt_vld <= 1'b0;
          if (!more) busy <= 1'b0;
        end else if (wr_en) begin
          nxt_q   <= wr_data;
          nxt_vld <= 1'b1;
        end
      end
    end
  end

  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (rst)
    ss_n |-> sck == $past(mode_cpol));                                    // R2
  AST_MOSI_WITH_SCK: assert property (@(posedge clk) disable iff (rst)
    (!ss_n && !$past(ss_n) && mosi != $past(mosi)) |-> sck != $past(sck)); // R5
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    data_req |=> !data_req);                                              // R7
  AST_RXV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);                                              // R6
  AST_RXV_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !ss_n);                                                  // R6
  AST_WORD_END_ALIGN: assert property (@(posedge clk) disable iff (rst)
    word_end |-> pos_q == PW'(WCYC - 1));                                 // R7
endmodule

// File: tb/spi_clken_master_bench.sv
`timescale 1ns/1ps
module spi_clken_master_bench;
  localparam int W    = 8;
  localparam int DIV  = 4;
  localparam int PF   = 3;
  localparam int HALF = DIV / 2;
  localparam int WCYC = W * DIV;

  logic clk = 1'b0, rst = 1'b1;
  logic mode_cpol = 1'b0, mode_cpha = 1'b0, wr_en = 1'b0, miso = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic data_req, rx_valid, sck, mosi, ss_n;
  logic [W-1:0] rx_data;

  spi_clken_master #(.WORD_W(W), .CLK_DIV(DIV), .PREFETCH(PF)) u_spi_clken_master (
    .clk(clk), .rst(rst), .mode_cpol(mode_cpol), .mode_cpha(mode_cpha),
    .wr_en(wr_en), .wr_data(wr_data), .data_req(data_req), .rx_data(rx_data),
    .rx_valid(rx_valid), .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso));

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [W-1:0] m_words [4];
  logic [W-1:0] s_words [4];
  logic [W-1:0] s_got [4];
  logic [W-1:0] m_got [4];
  logic [W-1:0] s_rx;
  int  s_got_n, m_got_n, n_bits, ss_low_cnt, req_cyc, rise_cyc, last_edge;
  int  hp_err, idle_err, rxv_err;
  bit  cur_cpol = 0, cur_cpha = 0, idle_chk = 0, have_edge = 0;
  logic prev_sck = 1'b0, prev_ss = 1'b1, prev_rxv = 1'b0;

  function automatic logic sbit(input int n);
    return s_words[(n / W) % 4][W - 1 - (n % W)];
  endfunction

  // slave model and timing monitor, sampled away from the active edge
  always @(negedge clk) begin
    bit chg, lead, smp_edge;
    chg  = sck != prev_sck;
    lead = chg && (sck != cur_cpol);
    smp_edge = cur_cpha ? (chg && !lead) : lead;
    if (!rst) begin
      if (prev_ss && !ss_n) begin
        n_bits = 0; ss_low_cnt = 0;
        miso <= sbit(0);
        have_edge = chg; last_edge = cyc;
      end
      if (!prev_ss && ss_n) rise_cyc = cyc;
      if (!ss_n) begin
        ss_low_cnt++;
        if (chg && !prev_ss) begin
          if (have_edge && cyc - last_edge != HALF) hp_err++;
          have_edge = 1; last_edge = cyc;
        end
        if (smp_edge) begin
          s_rx = {s_rx[W-2:0], mosi};
          n_bits++;
          if (n_bits % W == 0 && s_got_n < 4) begin
            s_got[s_got_n] = s_rx; s_got_n++;
          end
        end else if (chg) begin
          miso <= sbit(n_bits);
        end
      end
      if (ss_n && prev_ss && idle_chk && sck != cur_cpol) idle_err++;
      if (data_req) req_cyc = cyc;
      if (rx_valid) begin
        if (prev_rxv) rxv_err++;
        if (m_got_n < 4) begin m_got[m_got_n] = rx_data; m_got_n++; end
      end
    end
    prev_sck = sck; prev_ss = ss_n; prev_rxv = rx_valid;
  end

  task automatic set_mode(input bit pol, input bit pha);
    idle_chk = 0;
    @(negedge clk);
    mode_cpol = pol; mode_cpha = pha;
    repeat (2) @(negedge clk);
    cur_cpol = pol; cur_cpha = pha; idle_chk = 1;
  endtask

  task automatic xfer(input bit pol, input bit pha, input int nw, input bit flip,
                      input logic [W-1:0] mb, input logic [W-1:0] sb, input string name);
    set_mode(pol, pha);
    for (int k = 0; k < 4; k++) begin
      m_words[k] = mb + W'(k * 8'h35);
      s_words[k] = sb ^ W'(k * 8'h5a);
    end
    s_got_n = 0; m_got_n = 0; hp_err = 0; rxv_err = 0; idle_err = 0;
    req_cyc = 0; rise_cyc = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_data = m_words[0];
    @(negedge clk);
    wr_en = 1'b0;
    chk(ss_n === 1'b1, {"R3 ss_n still high one edge after strobe ", name}, ss_n, 1);
    @(negedge clk);
    chk(ss_n === 1'b0, {"R3 ss_n low on second edge ", name}, ss_n, 0);
    for (int k = 1; k < nw; k++) begin
      for (int t = 0; t < 200 && !data_req; t++) @(negedge clk);
      wr_en = 1'b1; wr_data = m_words[k];
      @(negedge clk);
      wr_en = 1'b0;
    end
    if (flip) begin
      repeat (8) @(negedge clk);
      mode_cpol = ~pol; mode_cpha = ~pha;
      repeat (8) @(negedge clk);
      mode_cpol = pol; mode_cpha = pha;
    end
    for (int t = 0; t < 1000 && !ss_n; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(s_got_n == nw, {"R4 slave word count ", name}, s_got_n, nw);
    chk(m_got_n == nw, {"R6 rx_valid count ", name}, m_got_n, nw);
    for (int k = 0; k < nw; k++) begin
      chk(s_got[k] == m_words[k], {"R4 mosi word, MSB first ", name}, s_got[k], m_words[k]);
      chk(m_got[k] == s_words[k], {"R6 rx_data word ", name}, m_got[k], s_words[k]);
    end
    if (nw > 1)
      chk(ss_low_cnt == nw * WCYC, {"R8 ss_n held low across words ", name}, ss_low_cnt, nw * WCYC);
    else
      chk(ss_low_cnt == WCYC, {"R9 ss_n released after final bit ", name}, ss_low_cnt, WCYC);
    chk(rise_cyc - req_cyc == PF + 2, {"R7 data_req lead ", name}, rise_cyc - req_cyc, PF + 2);
    chk(hp_err == 0, {"R1 half-period errors ", name}, hp_err, 0);
    chk(idle_err == 0, {"R2 idle sck errors ", name}, idle_err, 0);
    chk(rxv_err == 0, {"R6 rx_valid wider than one cycle ", name}, rxv_err, 0);
  endtask

  task automatic t_reset_state;
    chk(ss_n === 1'b1, "R10 ss_n in reset", ss_n, 1);
    chk(rx_valid === 1'b0, "R10 rx_valid in reset", rx_valid, 0);
    chk(data_req === 1'b0, "R10 data_req in reset", data_req, 0);
    chk(sck === 1'b0, "R10 sck idle in reset", sck, 0);
  endtask

  task automatic t_reset_mid;
    set_mode(1'b1, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h3c;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (12) @(negedge clk);
    idle_chk = 0;
    rst = 1'b1;
    @(negedge clk);
    chk(ss_n === 1'b1, "R10 ss_n after mid-word reset", ss_n, 1);
    chk(sck === 1'b1, "R10 sck idle after mid-word reset", sck, 1);
    chk(rx_valid === 1'b0, "R10 rx_valid after mid-word reset", rx_valid, 0);
    rst = 1'b0;
    repeat (WCYC + 4) @(negedge clk);
    chk(ss_n === 1'b1, "R10 no transfer resumes after reset", ss_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    xfer(1'b0, 1'b0, 1, 1'b0, 8'ha5, 8'h96, "mode0 single");
    xfer(1'b0, 1'b1, 1, 1'b0, 8'h81, 8'h7e, "mode1 single");
    xfer(1'b1, 1'b0, 1, 1'b0, 8'h01, 8'h80, "mode2 single");
    xfer(1'b1, 1'b1, 3, 1'b0, 8'hc3, 8'h5a, "mode3 burst");
    xfer(1'b0, 1'b0, 2, 1'b0, 8'hf0, 8'h0f, "mode0 burst");
    xfer(1'b0, 1'b1, 1, 1'b1, 8'h6d, 8'hb2, "R12 mode pins toggled mid-word");
    xfer(1'b1, 1'b0, 2, 1'b1, 8'h17, 8'he8, "R12 mode pins toggled in burst");
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule